// File: doc/BRIEF.md
# Eight-bit Timer with Shared Prescaler

The block is an 8-bit timer/counter for a small controller core. It counts either the instruction-cycle enable or edges on an external counter pin. A single programmable divider sits beside it. A control field assigns that divider either to the timer, where it acts as a prescaler, or to a watchdog tick path, where it acts as a postscaler. Whichever consumer does not hold the divider sees its events one for one.

Software loads the timer value and the control field through two write ports. When the timer wraps from 0xFF to 0x00 it sets a sticky overflow flag. The interrupt-control logic reads that flag, and software clears it with a dedicated strobe. The watchdog path takes ticks from an oscillator outside the block and returns a one-cycle expiry pulse.

Top module: `t0_timer_unit`

## Requirements
- R1: During and straight after reset, `tmr_value` is 0x00, `tmr_ovf` is 0 and `wdt_expire` is 0. The control field resets to external source, falling edge, divider given to the watchdog, and rate code 7.
- R2: When control bit 5 is 0, the count source is `cyc_en`. Each clock with `cyc_en` high is one source event.
- R3: When control bit 5 is 1 and bit 4 is 0, each rising edge of `ext_pin` is one source event. The pin passes through two synchronizer flops and one history flop, so the timer moves on the third clock edge after the pin changes.
- R4: When control bit 5 is 1 and bit 4 is 1, only falling edges of `ext_pin` are source events.
- R5: When control bit 3 is 0, the divider belongs to the timer. The timer then advances once per 2 << rate source events, where rate is control bits 2:0 (1:2 up to 1:256).
- R6: When control bit 3 is 1, the divider belongs to the watchdog. The timer advances on every source event, and `wdt_expire` pulses once per 1 << rate `wdt_tick` pulses (1:1 up to 1:128), one clock after the tick that completes the count.
- R7: While the divider belongs to the timer, `wdt_expire` equals `wdt_tick` delayed by one clock.
- R8: A timer write (`tmr_wr_en`) loads `tmr_wr_data` on the next clock and clears the divider count. No source events are accepted until two more `cyc_en` cycles have passed.
- R9: `tmr_ovf` sets when an increment takes the timer from 0xFF to 0x00. It stays set until `ovf_clr` is high. If a set and a clear fall in the same clock, the set wins.
- R10: A control write (`opt_wr_en`) clears the divider count. The new field takes effect from the next clock.
- R11: Bits 7:6 of `opt_wr_data` have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle enable, one clock wide |
| ext_pin | input | 1 | External counter pin, asynchronous |
| tmr_wr_en | input | 1 | Timer write strobe |
| tmr_wr_data | input | 8 | Timer write value |
| opt_wr_en | input | 1 | Control field write strobe |
| opt_wr_data | input | 8 | Control value: [5] source, [4] edge, [3] owner, [2:0] rate |
| ovf_clr | input | 1 | Clears the overflow flag |
| wdt_tick | input | 1 | Watchdog oscillator tick, one clock wide |
| tmr_value | output | 8 | Current timer value |
| tmr_ovf | output | 1 | Sticky overflow flag |
| wdt_expire | output | 1 | Watchdog expiry pulse |

## Verification
The assertions assume that `cyc_en` and `wdt_tick` are single-clock strobes, synchronous to `clk`, and that register writes never overlap reset. They also take the overflow rule to mean that nothing other than a write can make the timer jump by more than one. The stimulus drives every input once per clock from a single driver task, keeping the strobes synchronous. It holds `ext_pin` steady for at least three clocks between changes, so that the synchronizer never merges two edges.

// File: rtl/t0_pkg.sv
// Package: shared control-field layout and reset value for the timer unit.
// Assumes the rate code is three bits wide; field order sets the write layout.
package t0_pkg;

    localparam int RATE_W = 3;

    // Control field: source select, edge select, divider owner, rate code.
    typedef struct packed {
        logic              src_ext;
        logic              edge_fall;
        logic              psc_wdt;
        logic [RATE_W-1:0] rate;
    } t0_cfg_t;

    localparam int CFG_W = RATE_W + 3;

    localparam t0_cfg_t CFG_RESET = '{
        src_ext:   1'b1,
        edge_fall: 1'b1,
        psc_wdt:   1'b1,
        rate:      {RATE_W{1'b1}}
    };

endpackage

// File: rtl/t0_pin_edge.sv
// Module: synchronizes the external counter pin and flags the selected edge.
// Assumes SYNC_STAGES >= 2. The edge pulse is one clock wide and comes from
// the last synchronizer stage compared with a history flop.
module t0_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_evt
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   rise_w;
    logic                   fall_w;

    // Shift the raw pin through the synchronizer chain and keep one history bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Decode both edges and pick the one the control field asks for.
    always_comb begin
        rise_w   = sync_q[SYNC_STAGES-1] & ~last_q;
        fall_w   = ~sync_q[SYNC_STAGES-1] & last_q;
        edge_evt = fall_sel ? fall_w : rise_w;
    end

endmodule

// File: rtl/t0_prescaler.sv
// Module: the single divider shared by the timer and the watchdog path.
// The terminal count depends on the owner: 2<<rate - 1 for the timer and
// 1<<rate - 1 for the watchdog. A clear returns the count to zero.
// Assumes CNT_W >= 2**RATE_W, so that the largest ratio fits.
module t0_prescaler #(
    parameter int RATE_W = 3,
    parameter int CNT_W  = 1 << RATE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              evt_in,
    input  logic              to_wdt,
    input  logic [RATE_W-1:0] rate,
    output logic              hit
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Terminal count for the current owner and rate.
    always_comb begin
        if (to_wdt) begin
            limit = CNT_W'((1 << rate) - 1);
        end else begin
            limit = CNT_W'((2 << rate) - 1);
        end
        hit = evt_in && (cnt_q == limit);
    end

    // Advance on each input event, wrap at terminal count, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (evt_in) begin
            cnt_q <= hit ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/t0_count.sv
// Module: timer register, sticky overflow flag and post-write hold-off.
// A write loads the value and starts a hold-off of HOLD_CYC instruction
// cycles. While the hold-off runs, hold_busy is high and the top gates off
// source events. The overflow flag sets on the wrap; on a tie, set beats clear.
module t0_count #(
    parameter int TMR_W    = 8,
    parameter int HOLD_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TMR_W-1:0] wr_data,
    input  logic             cyc_en,
    input  logic             inc,
    input  logic             ovf_clr,
    output logic [TMR_W-1:0] value,
    output logic             ovf,
    output logic             hold_busy
);

    localparam int HOLD_W = $clog2(HOLD_CYC + 1);

    logic [HOLD_W-1:0] hold_q;
    logic              wrap_w;

    assign hold_busy = (hold_q != '0);
    assign wrap_w    = inc && !wr_en && (value == {TMR_W{1'b1}});

    // Timer register: a write has priority over an increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (wr_en) begin
            value <= wr_data;
        end else if (inc) begin
            value <= value + 1'b1;
        end
    end

    // Sticky overflow flag; a wrap in the same clock overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (wrap_w) begin
            ovf <= 1'b1;
        end else if (ovf_clr) begin
            ovf <= 1'b0;
        end
    end

    // Hold-off counter: loaded by a write, drained by instruction cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (wr_en) begin
            hold_q <= HOLD_W'(HOLD_CYC);
        end else if (hold_busy && cyc_en) begin
            hold_q <= hold_q - 1'b1;
        end
    end

endmodule

// File: rtl/t0_timer_unit.sv
// Module: top of the timer unit. Holds the control field and routes the
// shared divider to the timer or the watchdog path.
// Assumes cyc_en and wdt_tick are one-clock strobes synchronous to clk.
// ext_pin may be asynchronous.
module t0_timer_unit
    import t0_pkg::*;
#(
    parameter int TMR_W       = 8,
    parameter int HOLD_CYC    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             ext_pin,
    input  logic             tmr_wr_en,
    input  logic [TMR_W-1:0] tmr_wr_data,
    input  logic             opt_wr_en,
    input  logic [7:0]       opt_wr_data,
    input  logic             ovf_clr,
    input  logic             wdt_tick,
    output logic [TMR_W-1:0] tmr_value,
    output logic             tmr_ovf,
    output logic             wdt_expire
);

    localparam int CNT_W = 1 << RATE_W;

    t0_cfg_t cfg_q;
    logic    psc_to_wdt;
    logic    pin_evt;
    logic    src_evt;
    logic    div_in;
    logic    div_hit;
    logic    tmr_inc;
    logic    hold_busy;

    assign psc_to_wdt = cfg_q.psc_wdt;

    // Control field register; the upper write bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (opt_wr_en) begin
            cfg_q <= t0_cfg_t'(opt_wr_data[CFG_W-1:0]);
        end
    end

    t0_pin_edge #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ext_pin),
        .fall_sel (cfg_q.edge_fall),
        .edge_evt (pin_evt)
    );

    // Pick the count source, gate it during hold-off, and route the divider.
    always_comb begin
        src_evt = (cfg_q.src_ext ? pin_evt : cyc_en) && !hold_busy;
        div_in  = psc_to_wdt ? wdt_tick : src_evt;
        tmr_inc = psc_to_wdt ? src_evt : div_hit;
    end

    t0_prescaler #(
        .RATE_W(RATE_W),
        .CNT_W (CNT_W)
    ) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_wr_en || opt_wr_en),
        .evt_in (div_in),
        .to_wdt (psc_to_wdt),
        .rate   (cfg_q.rate),
        .hit    (div_hit)
    );

    t0_count #(
        .TMR_W   (TMR_W),
        .HOLD_CYC(HOLD_CYC)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (tmr_wr_en),
        .wr_data   (tmr_wr_data),
        .cyc_en    (cyc_en),
        .inc       (tmr_inc),
        .ovf_clr   (ovf_clr),
        .value     (tmr_value),
        .ovf       (tmr_ovf),
        .hold_busy (hold_busy)
    );

    // Watchdog expiry: divided when the divider is owned, else the raw tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_expire <= 1'b0;
        end else begin
            wdt_expire <= psc_to_wdt ? div_hit : wdt_tick;
        end
    end

endmodule

// File: rtl/t0_timer_unit_chk.sv
// Checker: temporal properties of the timer unit, seen from its ports and
// the divider-owner bit. It is attached to every instance by the bind below.
module t0_timer_unit_chk #(
    parameter int TMR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tmr_wr_en,
    input logic [TMR_W-1:0] tmr_wr_data,
    input logic             ovf_clr,
    input logic             wdt_tick,
    input logic             psc_to_wdt,
    input logic [TMR_W-1:0] tmr_value,
    input logic             tmr_ovf,
    input logic             wdt_expire
);

    AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wr_en |=> tmr_value == $past(tmr_wr_data)); // R8

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wr_en ##1 !tmr_wr_en |=> $stable(tmr_value)); // R8

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_wr_en |=> (tmr_value == $past(tmr_value)) ||
                       (tmr_value == TMR_W'($past(tmr_value) + 1'b1))); // R2

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf && !ovf_clr |=> tmr_ovf); // R9

    AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_ovf) |-> ($past(tmr_value) == {TMR_W{1'b1}}) &&
                           (tmr_value == '0)); // R9

    AST_WDT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !psc_to_wdt |=> wdt_expire == $past(wdt_tick)); // R7

    AST_WDT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_expire |-> $past(wdt_tick)); // R6

endmodule

bind t0_timer_unit t0_timer_unit_chk #(.TMR_W(TMR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tmr_wr_en   (tmr_wr_en),
    .tmr_wr_data (tmr_wr_data),
    .ovf_clr     (ovf_clr),
    .wdt_tick    (wdt_tick),
    .psc_to_wdt  (psc_to_wdt),
    .tmr_value   (tmr_value),
    .tmr_ovf     (tmr_ovf),
    .wdt_expire  (wdt_expire)
);

// File: tb/t0_timer_unit_tb.sv
// Scoreboard bench: a driver task applies one clock of stimulus on the
// falling edge and pushes the expected outputs after the next rising edge.
// A monitor pops and compares 1 ns after each rising edge.
module t0_timer_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0, ext_pin = 1'b0, tmr_wr_en = 1'b0;
    logic [7:0] tmr_wr_data = '0;
    logic       opt_wr_en = 1'b0;
    logic [7:0] opt_wr_data = '0;
    logic       ovf_clr = 1'b0, wdt_tick = 1'b0;
    logic [7:0] tmr_value;
    logic       tmr_ovf, wdt_expire;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [9:0] exp_q[$];
    string      tag_q[$];

    // Reference state, kept from the requirements.
    int         m_tmr = 0, m_psc = 0, m_hold = 0;
    bit         m_ovf = 0, m_wdt = 0, m_s1 = 0, m_s2 = 0, m_s3 = 0;
    logic [5:0] m_cfg = 6'h3F;

    always #2 clk = ~clk;  // 250 MHz

    t0_timer_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
        .tmr_wr_en(tmr_wr_en), .tmr_wr_data(tmr_wr_data),
        .opt_wr_en(opt_wr_en), .opt_wr_data(opt_wr_data),
        .ovf_clr(ovf_clr), .wdt_tick(wdt_tick),
        .tmr_value(tmr_value), .tmr_ovf(tmr_ovf), .wdt_expire(wdt_expire)
    );

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s tmr/ovf/wdt act=%h/%b/%b exp=%h/%b/%b", tag,
                     act[9:2], act[1], act[0], exp[9:2], exp[1], exp[0]);
        end
    endtask

    // Apply one clock of inputs now, advance the model, queue the expectation.
    task automatic drive(input bit cyc, input bit pin, input bit twr, input logic [7:0] tdata,
                         input bit owr, input logic [7:0] odata, input bit clr, input bit tick,
                         input string tag);
        bit rise, fall, src, towdt, din, hit, inc;
        int lim;
        cyc_en = cyc; ext_pin = pin; tmr_wr_en = twr; tmr_wr_data = tdata;
        opt_wr_en = owr; opt_wr_data = odata; ovf_clr = clr; wdt_tick = tick;
        rise  = m_s2 && !m_s3;
        fall  = !m_s2 && m_s3;
        src   = m_cfg[5] ? (m_cfg[4] ? fall : rise) : cyc;   // R2 R3 R4
        if (m_hold != 0) src = 0;                            // R8
        towdt = m_cfg[3];
        lim   = towdt ? (1 << m_cfg[2:0]) - 1 : (2 << m_cfg[2:0]) - 1;  // R5 R6
        din   = towdt ? tick : src;
        hit   = din && (m_psc == lim);
        inc   = towdt ? src : hit;
        m_wdt = towdt ? hit : tick;                          // R6 R7
        if (!twr && inc && m_tmr == 255) m_ovf = 1;          // R9
        else if (clr) m_ovf = 0;
        if (twr || owr) m_psc = 0;                           // R8 R10
        else if (din) m_psc = hit ? 0 : m_psc + 1;
        if (twr) m_tmr = tdata;
        else if (inc) m_tmr = (m_tmr + 1) % 256;
        if (twr) m_hold = 2;
        else if (m_hold != 0 && cyc) m_hold = m_hold - 1;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin;
        if (owr) m_cfg = odata[5:0];                         // R11
        exp_q.push_back({8'(m_tmr), m_ovf, m_wdt});
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic [7:0] v, input string tag);
        drive(0, ext_pin, 0, 8'h00, 1, v, 0, 0, tag);
    endtask

    // Monitor: compare outputs against the oldest expectation.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            check(tag_q.pop_front(), {tmr_value, tmr_ovf, wdt_expire}, exp_q.pop_front());
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {tmr_value, tmr_ovf, wdt_expire}, 10'h000);  // R1 in reset
        rst_n = 1'b1;
        drive(0, 0, 0, 8'h00, 0, 8'h00, 0, 0, "R1");             // R1 after reset
        drive(0, 0, 0, 8'h00, 0, 8'h00, 0, 1, "R1");             // reset rate 7 holds tick

        // R2 / R6: internal source, divider to watchdog at 1:1.
        set_cfg(8'h08, "R2");
        for (int i = 0; i < 16; i++) drive(i % 2, 0, 0, 0, 0, 0, 0, (i % 3) == 0, "R2");

        // R5 / R7: divider to timer at 1:4, watchdog tick passes through.
        set_cfg(8'h01, "R5");
        for (int i = 0; i < 24; i++) drive(1, 0, 0, 0, 0, 0, 0, (i % 5) == 0, "R7");

        // R3: external rising edges, cycle enable toggling but unused.
        set_cfg(8'h28, "R3");
        for (int i = 0; i < 30; i++) drive(i % 2, (i / 3) % 2, 0, 0, 0, 0, 0, 0, "R3");

        // R4: external falling edges.
        set_cfg(8'h38, "R4");
        for (int i = 0; i < 30; i++) drive(1, (i / 4) % 2, 0, 0, 0, 0, 0, 0, "R4");

        // R8 / R9: load near the top, hold-off, wrap, sticky flag, clear.
        set_cfg(8'h08, "R8");
        drive(1, 0, 1, 8'hFD, 0, 0, 0, 0, "R8");
        for (int i = 0; i < 8; i++) drive(1, 0, 0, 0, 0, 0, 0, 0, "R9");
        drive(1, 0, 0, 0, 0, 0, 1, 0, "R9");
        drive(1, 0, 1, 8'hFF, 0, 0, 0, 0, "R8");
        drive(0, 0, 0, 0, 0, 0, 0, 0, "R8");
        drive(1, 0, 0, 0, 0, 0, 0, 0, "R8");
        drive(1, 0, 0, 0, 0, 0, 0, 0, "R8");
        drive(1, 0, 0, 0, 0, 0, 1, 0, "R9");                    // set beats clear
        for (int i = 0; i < 3; i++) drive(1, 0, 0, 0, 0, 0, 0, 0, "R9");

        // R6: watchdog postscale 1:4, timer idle.
        set_cfg(8'h0A, "R6");
        for (int i = 0; i < 20; i++) drive(0, 0, 0, 0, 0, 0, 0, 1, "R6");

        // R10: control write mid-count clears the 1:8 divider.
        set_cfg(8'h02, "R10");
        for (int i = 0; i < 5; i++) drive(1, 0, 0, 0, 0, 0, 0, 0, "R10");
        set_cfg(8'h02, "R10");
        for (int i = 0; i < 20; i++) drive(1, 0, 0, 0, 0, 0, 0, 0, "R10");

        // R11: upper control bits ignored.
        set_cfg(8'hC8, "R11");
        for (int i = 0; i < 8; i++) drive(1, 0, 0, 0, 0, 0, 0, i == 3, "R11");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule